// File: doc/BRIEF.md
# Regulator Voltage-Select Register Bank

This block holds the digital control state for a set of buck regulator channels (three by default). Each channel owns three byte-wide registers: a control register, a force register and a voltage register. A host reaches them through a simple byte read/write port. From those registers, three sleep/enable pins and per-channel pin-assignment masks, every channel resolves three results: the 7-bit voltage code it applies, the range bit, and the operating mode it runs in.

Factory defaults come in on static buses. The block reloads them under three reset domains and one warm-reset input. All resets are synchronous and active low: `por_n` is power-on, `sw_rst_n` is switch-off and `hw_rst_n` is hardware. `por_n` and `sw_rst_n` both clear every field. `hw_rst_n` clears only the hardware-domain control fields. A warm reset reloads the voltage codes of a channel only when that channel's warm-reset sensitivity bit is clear.

The address map gives channel `c` the slots `4c+0`, `4c+1` and `4c+2`, which hold control, force and voltage. Slot `4c+3` and every address at or above `4*NUM_CH` is unmapped.

Top module: `dvs_regbank`

## Requirements
- R1: After `por_n` or `sw_rst_n` is low at a clock edge, the registers reset as follows. Control reads 0x00. Force reads {1, OTP force code}. Voltage reads {OTP range bit, OTP voltage code}. `ch_mode` reads 00.
- R2: While control bit 6 (pin select) is 0, the channel applies a code chosen by force bit 7 (command). A command of 0 selects the force code in bits 6:0, and a command of 1 selects the voltage code in bits 6:0.
- R3: While control bit 6 is 1, the command bit has no effect. The pin selection is `(map_sleep & ~pin_sleep_n) | (map_en1 & pin_en1) | (map_en2 & pin_en2)`. A selected channel applies the force code, and a deselected channel applies the voltage code.
- R4: The effective mode is control bits 3:2 when the pins select the channel, and control bits 1:0 otherwise. The encodings are 00 off, 01 forced PWM, 10 economy and 11 forced PWM. `ch_mode` and control bits 5:4 show this mode one clock edge after the register or pin change.
- R5: A warm reset, on a channel whose control bit 7 is 0, reloads both voltage codes from OTP and sets the command bit to 1. It leaves the range bit unchanged.
- R6: A warm reset, on a channel whose control bit 7 is 1, leaves the force and voltage registers unchanged. Any register write in a warm-reset cycle is dropped.
- R7: A write to the voltage register updates the range bit (bit 7) only while the channel's registered mode is 00. The code bits are written in every case.
- R8: `hw_rst_n` low clears control bits 7, 6 and 5:4. It keeps the mode fields, the force register and the voltage register.
- R9: A read returns data one clock edge after `bus_rd`. A read of an unmapped address leaves `bus_rdata` at the value of the previous read. Writes to control bits 5:4 have no effect.
- R10: Channel `c` decodes control at `4c`, force at `4c+1` and voltage at `4c+2`. Writes to unmapped addresses change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, synchronous, active low |
| hw_rst_n | input | 1 | Hardware reset, synchronous, active low |
| sw_rst_n | input | 1 | Switch-off reset, synchronous, active low |
| warm_rst | input | 1 | Warm reset request, sampled each edge |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| otp_force_vsel | input | NUM_CH*VSEL_W | Default force codes |
| otp_volt_vsel | input | NUM_CH*VSEL_W | Default voltage codes |
| otp_range | input | NUM_CH | Default range bits |
| pin_sleep_n | input | 1 | Sleep pin, active low |
| pin_en1 | input | 1 | Enable pin 1 |
| pin_en2 | input | 1 | Enable pin 2 |
| map_sleep | input | NUM_CH | Channel responds to the sleep pin |
| map_en1 | input | NUM_CH | Channel responds to enable pin 1 |
| map_en2 | input | NUM_CH | Channel responds to enable pin 2 |
| ch_vsel | output | NUM_CH*VSEL_W | Applied voltage code per channel |
| ch_range | output | NUM_CH | Range bit per channel |
| ch_mode | output | NUM_CH*2 | Registered operating mode per channel |

## Verification
Register contents change at the clock edge that samples a write, a warm reset or a reset. `ch_vsel` and `ch_range` follow the registers combinationally, so they are due right after that edge. `ch_vsel` also follows pin changes with no delay. `ch_mode` lags by one more edge, and `bus_rdata` appears at the edge that samples `bus_rd`. The bench drives every input at the falling edge and advances a reference model at each rising edge. It compares all outputs at the next falling edge. The R4 and R7 checks therefore see exactly one edge of mode lag.

// File: rtl/dvs_pkg.sv
package dvs_pkg;
   typedef enum logic [1:0] {
      MODE_OFF  = 2'b00,
      MODE_PWM  = 2'b01,
      MODE_ECO  = 2'b10,
      MODE_PWM2 = 2'b11
   } mode_e;

   localparam int SLOT_W      = 2;
   localparam int SLOTS       = 1 << SLOT_W;
   localparam int REGS_PER_CH = 3;
   localparam int OFS_CTRL    = 0;
   localparam int OFS_FORCE   = 1;
   localparam int OFS_VOLT    = 2;

   // control byte bit positions
   localparam int CB_WRS  = 7;
   localparam int CB_PINS = 6;
   localparam int CB_STH  = 5;
   localparam int CB_SLH  = 3;
   localparam int CB_ACH  = 1;
endpackage

// File: rtl/dvs_chan_resolve.sv
module dvs_chan_resolve
   import dvs_pkg::*;
#(
   parameter int VSEL_W = 7
) (
   input  logic              pin_sleep_n,
   input  logic              pin_en1,
   input  logic              pin_en2,
   input  logic              map_sleep,
   input  logic              map_en1,
   input  logic              map_en2,
   input  logic              rf_en,
   input  logic              cmd,
   input  logic [1:0]        mode_slp,
   input  logic [1:0]        mode_act,
   input  logic [VSEL_W-1:0] f_vsel,
   input  logic [VSEL_W-1:0] v_vsel,
   output mode_e             mode_eff,
   output logic [VSEL_W-1:0] vsel_eff
);
   logic sel;
   logic use_force;

   always_comb begin
      sel       = (map_sleep & ~pin_sleep_n) | (map_en1 & pin_en1) | (map_en2 & pin_en2);
      mode_eff  = sel ? mode_e'(mode_slp) : mode_e'(mode_act);
      use_force = rf_en ? sel : ~cmd;
      vsel_eff  = use_force ? f_vsel : v_vsel;
   end
endmodule

// File: rtl/dvs_chan_regs.sv
module dvs_chan_regs
   import dvs_pkg::*;
#(
   parameter int VSEL_W = 7,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              por_n,
   input  logic              hw_rst_n,
   input  logic              sw_rst_n,
   input  logic              warm_rst,
   input  logic              wr_ctrl,
   input  logic              wr_force,
   input  logic              wr_volt,
   input  logic [DATA_W-1:0] wdata,
   input  logic [VSEL_W-1:0] otp_fv,
   input  logic [VSEL_W-1:0] otp_vv,
   input  logic              otp_rng,
   input  mode_e             mode_eff,
   output logic              wr_s,
   output logic              rf_en,
   output mode_e             status,
   output logic [1:0]        mode_slp,
   output logic [1:0]        mode_act,
   output logic              cmd,
   output logic [VSEL_W-1:0] f_vsel,
   output logic [VSEL_W-1:0] v_vsel,
   output logic              rng
);
   logic unused_status_bits;
   assign unused_status_bits = ^wdata[CB_STH -: 2];

   always_ff @(posedge clk) begin
      if (!por_n || !sw_rst_n) begin
         wr_s     <= 1'b0;
         rf_en    <= 1'b0;
         status   <= MODE_OFF;
         mode_slp <= 2'b00;
         mode_act <= 2'b00;
         cmd      <= 1'b1;
         f_vsel   <= otp_fv;
         v_vsel   <= otp_vv;
         rng      <= otp_rng;
      end else if (!hw_rst_n) begin
         wr_s   <= 1'b0;
         rf_en  <= 1'b0;
         status <= MODE_OFF;
      end else begin
         status <= mode_eff;
         if (warm_rst) begin
            if (!wr_s) begin
               cmd    <= 1'b1;
               f_vsel <= otp_fv;
               v_vsel <= otp_vv;
            end
         end else if (wr_ctrl) begin
            wr_s     <= wdata[CB_WRS];
            rf_en    <= wdata[CB_PINS];
            mode_slp <= wdata[CB_SLH -: 2];
            mode_act <= wdata[CB_ACH -: 2];
         end else if (wr_force) begin
            cmd    <= wdata[DATA_W-1];
            f_vsel <= wdata[VSEL_W-1:0];
         end else if (wr_volt) begin
            if (status == MODE_OFF) rng <= wdata[DATA_W-1];
            v_vsel <= wdata[VSEL_W-1:0];
         end
      end
   end
endmodule

// File: rtl/dvs_rd_mux.sv
module dvs_rd_mux
   import dvs_pkg::*;
#(
   parameter int NUM_CH = 3,
   parameter int DATA_W = 8,
   parameter int ADDR_W = 8,
   localparam int WORDS = NUM_CH * REGS_PER_CH
) (
   input  logic                    clk,
   input  logic                    por_n,
   input  logic                    rd_en,
   input  logic [ADDR_W-1:0]       addr,
   input  logic [WORDS*DATA_W-1:0] words,
   output logic [DATA_W-1:0]       rdata
);
   logic              hit;
   logic [DATA_W-1:0] word;

   always_comb begin
      hit  = 1'b0;
      word = '0;
      for (int c = 0; c < NUM_CH; c++) begin
         for (int r = 0; r < REGS_PER_CH; r++) begin
            if (addr == ADDR_W'(c * SLOTS + r)) begin
               hit  = 1'b1;
               word = words[(c*REGS_PER_CH+r)*DATA_W +: DATA_W];
            end
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!por_n)             rdata <= '0;
      else if (rd_en && hit)  rdata <= word;
   end
endmodule

// File: rtl/dvs_regbank.sv
module dvs_regbank
   import dvs_pkg::*;
#(
   parameter int NUM_CH = 3,
   parameter int VSEL_W = 7,
   parameter int DATA_W = 8,
   parameter int ADDR_W = 8
) (
   input  logic                     clk,
   input  logic                     por_n,
   input  logic                     hw_rst_n,
   input  logic                     sw_rst_n,
   input  logic                     warm_rst,
   input  logic                     bus_wr,
   input  logic                     bus_rd,
   input  logic [ADDR_W-1:0]        bus_addr,
   input  logic [DATA_W-1:0]        bus_wdata,
   output logic [DATA_W-1:0]        bus_rdata,
   input  logic [NUM_CH*VSEL_W-1:0] otp_force_vsel,
   input  logic [NUM_CH*VSEL_W-1:0] otp_volt_vsel,
   input  logic [NUM_CH-1:0]        otp_range,
   input  logic                     pin_sleep_n,
   input  logic                     pin_en1,
   input  logic                     pin_en2,
   input  logic [NUM_CH-1:0]        map_sleep,
   input  logic [NUM_CH-1:0]        map_en1,
   input  logic [NUM_CH-1:0]        map_en2,
   output logic [NUM_CH*VSEL_W-1:0] ch_vsel,
   output logic [NUM_CH-1:0]        ch_range,
   output logic [NUM_CH*2-1:0]      ch_mode
);
   localparam int WORDS = NUM_CH * REGS_PER_CH;

   if (DATA_W != 8) begin : g_bad_data
      $error("control byte layout needs DATA_W of 8");
   end
   if (VSEL_W != DATA_W - 1) begin : g_bad_vsel
      $error("VSEL_W must be DATA_W-1");
   end
   if (NUM_CH < 1 || NUM_CH * SLOTS > (1 << ADDR_W)) begin : g_bad_map
      $error("channel map does not fit the address space");
   end

   logic [NUM_CH-1:0]        wr_s_vec;
   logic [NUM_CH-1:0]        cmd_vec;
   logic [NUM_CH*VSEL_W-1:0] f_vsel_vec;
   logic [NUM_CH*VSEL_W-1:0] v_vsel_vec;
   logic [NUM_CH*2-1:0]      mode_act_vec;
   logic [NUM_CH*2-1:0]      mode_slp_vec;
   logic [WORDS*DATA_W-1:0]  rd_words;

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      logic              wr_ctrl, wr_force, wr_volt;
      logic              rf_en;
      mode_e             status, mode_eff;
      logic [VSEL_W-1:0] vsel_eff;

      assign wr_ctrl  = bus_wr && (bus_addr == ADDR_W'(c * SLOTS + OFS_CTRL));
      assign wr_force = bus_wr && (bus_addr == ADDR_W'(c * SLOTS + OFS_FORCE));
      assign wr_volt  = bus_wr && (bus_addr == ADDR_W'(c * SLOTS + OFS_VOLT));

      dvs_chan_regs #(.VSEL_W(VSEL_W), .DATA_W(DATA_W)) u_regs (
         .clk      (clk),
         .por_n    (por_n),
         .hw_rst_n (hw_rst_n),
         .sw_rst_n (sw_rst_n),
         .warm_rst (warm_rst),
         .wr_ctrl  (wr_ctrl),
         .wr_force (wr_force),
         .wr_volt  (wr_volt),
         .wdata    (bus_wdata),
         .otp_fv   (otp_force_vsel[c*VSEL_W +: VSEL_W]),
         .otp_vv   (otp_volt_vsel[c*VSEL_W +: VSEL_W]),
         .otp_rng  (otp_range[c]),
         .mode_eff (mode_eff),
         .wr_s     (wr_s_vec[c]),
         .rf_en    (rf_en),
         .status   (status),
         .mode_slp (mode_slp_vec[c*2 +: 2]),
         .mode_act (mode_act_vec[c*2 +: 2]),
         .cmd      (cmd_vec[c]),
         .f_vsel   (f_vsel_vec[c*VSEL_W +: VSEL_W]),
         .v_vsel   (v_vsel_vec[c*VSEL_W +: VSEL_W]),
         .rng      (ch_range[c])
      );

      dvs_chan_resolve #(.VSEL_W(VSEL_W)) u_res (
         .pin_sleep_n (pin_sleep_n),
         .pin_en1     (pin_en1),
         .pin_en2     (pin_en2),
         .map_sleep   (map_sleep[c]),
         .map_en1     (map_en1[c]),
         .map_en2     (map_en2[c]),
         .rf_en       (rf_en),
         .cmd         (cmd_vec[c]),
         .mode_slp    (mode_slp_vec[c*2 +: 2]),
         .mode_act    (mode_act_vec[c*2 +: 2]),
         .f_vsel      (f_vsel_vec[c*VSEL_W +: VSEL_W]),
         .v_vsel      (v_vsel_vec[c*VSEL_W +: VSEL_W]),
         .mode_eff    (mode_eff),
         .vsel_eff    (vsel_eff)
      );

      assign ch_vsel[c*VSEL_W +: VSEL_W] = vsel_eff;
      assign ch_mode[c*2 +: 2]           = status;

      assign rd_words[(c*REGS_PER_CH+OFS_CTRL)*DATA_W +: DATA_W] =
         {wr_s_vec[c], rf_en, status, mode_slp_vec[c*2 +: 2], mode_act_vec[c*2 +: 2]};
      assign rd_words[(c*REGS_PER_CH+OFS_FORCE)*DATA_W +: DATA_W] =
         {cmd_vec[c], f_vsel_vec[c*VSEL_W +: VSEL_W]};
      assign rd_words[(c*REGS_PER_CH+OFS_VOLT)*DATA_W +: DATA_W] =
         {ch_range[c], v_vsel_vec[c*VSEL_W +: VSEL_W]};
   end

   dvs_rd_mux #(.NUM_CH(NUM_CH), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_rd (
      .clk   (clk),
      .por_n (por_n),
      .rd_en (bus_rd),
      .addr  (bus_addr),
      .words (rd_words),
      .rdata (bus_rdata)
   );
endmodule

// File: rtl/dvs_regbank_chk.sv
module dvs_regbank_chk #(
   parameter int NUM_CH = 3,
   parameter int VSEL_W = 7,
   parameter int DATA_W = 8,
   parameter int ADDR_W = 8
) (
   input logic                     clk,
   input logic                     por_n,
   input logic                     hw_rst_n,
   input logic                     sw_rst_n,
   input logic                     warm_rst,
   input logic                     bus_wr,
   input logic                     bus_rd,
   input logic [ADDR_W-1:0]        bus_addr,
   input logic [DATA_W-1:0]        bus_rdata,
   input logic [NUM_CH*VSEL_W-1:0] otp_force_vsel,
   input logic [NUM_CH*VSEL_W-1:0] otp_volt_vsel,
   input logic [NUM_CH-1:0]        ch_range,
   input logic [NUM_CH*2-1:0]      ch_mode,
   input logic [NUM_CH-1:0]        wr_s_vec,
   input logic [NUM_CH-1:0]        cmd_vec,
   input logic [NUM_CH*VSEL_W-1:0] f_vsel_vec,
   input logic [NUM_CH*VSEL_W-1:0] v_vsel_vec,
   input logic [NUM_CH*2-1:0]      mode_act_vec,
   input logic [NUM_CH*2-1:0]      mode_slp_vec
);
   logic mapped;
   always_comb begin
      mapped = 1'b0;
      for (int c = 0; c < NUM_CH; c++)
         for (int r = 0; r < 3; r++)
            if (bus_addr == ADDR_W'(c * 4 + r)) mapped = 1'b1;
   end

   p_unmapped_hold_r9: assert property (@(posedge clk) disable iff (!por_n)
      bus_rd && !mapped |=> $stable(bus_rdata));

   for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
      p_range_lock_r7: assert property (@(posedge clk) disable iff (!por_n || !sw_rst_n)
         bus_wr && bus_addr == ADDR_W'(c * 4 + 2) && ch_mode[c*2 +: 2] != 2'b00
         |=> $stable(ch_range[c]));

      p_warm_reload_r5: assert property (@(posedge clk)
         disable iff (!por_n || !sw_rst_n || !hw_rst_n)
         warm_rst && !wr_s_vec[c]
         |=> cmd_vec[c] && f_vsel_vec[c*VSEL_W +: VSEL_W] == otp_force_vsel[c*VSEL_W +: VSEL_W]
             && v_vsel_vec[c*VSEL_W +: VSEL_W] == otp_volt_vsel[c*VSEL_W +: VSEL_W]);

      p_warm_keep_r6: assert property (@(posedge clk)
         disable iff (!por_n || !sw_rst_n || !hw_rst_n)
         warm_rst && wr_s_vec[c]
         |=> $stable(cmd_vec[c]) && $stable(f_vsel_vec[c*VSEL_W +: VSEL_W])
             && $stable(v_vsel_vec[c*VSEL_W +: VSEL_W]) && $stable(ch_range[c]));

      p_hw_keep_r8: assert property (@(posedge clk) disable iff (!por_n || !sw_rst_n)
         !hw_rst_n
         |=> $stable(mode_act_vec[c*2 +: 2]) && $stable(mode_slp_vec[c*2 +: 2])
             && $stable(f_vsel_vec[c*VSEL_W +: VSEL_W]) && ch_mode[c*2 +: 2] == 2'b00
             && !wr_s_vec[c]);

      p_off_lag_r4: assert property (@(posedge clk)
         disable iff (!por_n || !sw_rst_n || !hw_rst_n)
         mode_act_vec[c*2 +: 2] == 2'b00 && mode_slp_vec[c*2 +: 2] == 2'b00
         |=> ch_mode[c*2 +: 2] == 2'b00);

      p_reset_cmd_r1: assert property (@(posedge clk) disable iff (!por_n)
         !sw_rst_n |=> cmd_vec[c] && ch_mode[c*2 +: 2] == 2'b00
                       && mode_act_vec[c*2 +: 2] == 2'b00);
   end
endmodule

bind dvs_regbank dvs_regbank_chk #(
   .NUM_CH(NUM_CH), .VSEL_W(VSEL_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
) u_chk (
   .clk            (clk),
   .por_n          (por_n),
   .hw_rst_n       (hw_rst_n),
   .sw_rst_n       (sw_rst_n),
   .warm_rst       (warm_rst),
   .bus_wr         (bus_wr),
   .bus_rd         (bus_rd),
   .bus_addr       (bus_addr),
   .bus_rdata      (bus_rdata),
   .otp_force_vsel (otp_force_vsel),
   .otp_volt_vsel  (otp_volt_vsel),
   .ch_range       (ch_range),
   .ch_mode        (ch_mode),
   .wr_s_vec       (wr_s_vec),
   .cmd_vec        (cmd_vec),
   .f_vsel_vec     (f_vsel_vec),
   .v_vsel_vec     (v_vsel_vec),
   .mode_act_vec   (mode_act_vec),
   .mode_slp_vec   (mode_slp_vec)
);

// File: tb/tb_dvs_regbank.sv
module tb_dvs_regbank;
   localparam int NCH = 3;
   localparam int VW  = 7;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic por_n = 1'b0, hw_rst_n = 1'b1, sw_rst_n = 1'b1, warm_rst = 1'b0;
   logic bus_wr = 1'b0, bus_rd = 1'b0;
   logic [7:0] bus_addr = '0, bus_wdata = '0;
   logic [7:0] bus_rdata;
   logic [NCH*VW-1:0] otp_f = {7'h40, 7'h2A, 7'h15};
   logic [NCH*VW-1:0] otp_v = {7'h33, 7'h0C, 7'h61};
   logic [NCH-1:0] otp_r = 3'b101;
   logic pin_sleep_n = 1'b1, pin_en1 = 1'b0, pin_en2 = 1'b0;
   logic [NCH-1:0] map_sleep = '0, map_en1 = '0, map_en2 = '0;
   logic [NCH*VW-1:0] ch_vsel;
   logic [NCH-1:0] ch_range;
   logic [NCH*2-1:0] ch_mode;

   dvs_regbank dut (
      .clk(clk), .por_n(por_n), .hw_rst_n(hw_rst_n), .sw_rst_n(sw_rst_n),
      .warm_rst(warm_rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .otp_force_vsel(otp_f),
      .otp_volt_vsel(otp_v), .otp_range(otp_r), .pin_sleep_n(pin_sleep_n),
      .pin_en1(pin_en1), .pin_en2(pin_en2), .map_sleep(map_sleep),
      .map_en1(map_en1), .map_en2(map_en2), .ch_vsel(ch_vsel),
      .ch_range(ch_range), .ch_mode(ch_mode)
   );

   typedef struct {
      bit wrs, rf, cmd, rng;
      bit [1:0] st, ms, ma;
      bit [6:0] fv, vv;
   } ch_t;

   ch_t m[NCH];
   bit [7:0] m_rd;
   int n_chk = 0, n_fail = 0;
   bit done = 0;

   task automatic chk(bit ok, string tag, int act, int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   function automatic bit sel_of(int c);
      return (map_sleep[c] & ~pin_sleep_n) | (map_en1[c] & pin_en1) | (map_en2[c] & pin_en2);
   endfunction

   function automatic bit [6:0] exp_vsel(int c);
      bit uf;
      uf = m[c].rf ? sel_of(c) : !m[c].cmd;
      return uf ? m[c].fv : m[c].vv;
   endfunction

   // returns channel of a mapped address, or -1
   function automatic int ch_of(bit [7:0] a);
      if (a[1:0] == 2'd3 || int'(a >> 2) >= NCH) return -1;
      return int'(a >> 2);
   endfunction

   function automatic bit [7:0] word_of(int c, int slot);
      if (slot == 0) return {m[c].wrs, m[c].rf, m[c].st, m[c].ms, m[c].ma};
      if (slot == 1) return {m[c].cmd, m[c].fv};
      return {m[c].rng, m[c].vv};
   endfunction

   // advance the reference model by one clock edge, using the driven inputs
   task automatic tick();
      ch_t n[NCH];
      bit [7:0] nrd;
      int wc;
      n = m;
      nrd = m_rd;
      if (!por_n) nrd = '0;
      else if (bus_rd && ch_of(bus_addr) >= 0) nrd = word_of(ch_of(bus_addr), int'(bus_addr[1:0]));
      wc = bus_wr ? ch_of(bus_addr) : -1;
      for (int c = 0; c < NCH; c++) begin
         if (!por_n || !sw_rst_n) begin
            n[c].wrs = 0; n[c].rf = 0; n[c].st = 0; n[c].ms = 0; n[c].ma = 0;
            n[c].cmd = 1; n[c].fv = otp_f[c*VW +: VW]; n[c].vv = otp_v[c*VW +: VW];
            n[c].rng = otp_r[c];
         end else if (!hw_rst_n) begin
            n[c].wrs = 0; n[c].rf = 0; n[c].st = 0;
         end else begin
            n[c].st = sel_of(c) ? m[c].ms : m[c].ma;
            if (warm_rst) begin
               if (!m[c].wrs) begin
                  n[c].cmd = 1; n[c].fv = otp_f[c*VW +: VW]; n[c].vv = otp_v[c*VW +: VW];
               end
            end else if (wc == c) begin
               case (bus_addr[1:0])
                  2'd0: begin
                     n[c].wrs = bus_wdata[7]; n[c].rf = bus_wdata[6];
                     n[c].ms = bus_wdata[3:2]; n[c].ma = bus_wdata[1:0];
                  end
                  2'd1: begin n[c].cmd = bus_wdata[7]; n[c].fv = bus_wdata[6:0]; end
                  default: begin
                     if (m[c].st == 2'b00) n[c].rng = bus_wdata[7];
                     n[c].vv = bus_wdata[6:0];
                  end
               endcase
            end
         end
      end
      @(posedge clk);
      m = n;
      m_rd = nrd;
      @(negedge clk);
   endtask

   task automatic check_outs(string tv, string tm);
      for (int c = 0; c < NCH; c++) begin
         chk(ch_vsel[c*VW +: VW] == exp_vsel(c), tv, ch_vsel[c*VW +: VW], exp_vsel(c));
         chk(ch_mode[c*2 +: 2] == m[c].st, tm, ch_mode[c*2 +: 2], m[c].st);
         chk(ch_range[c] == m[c].rng, "R7 range", ch_range[c], m[c].rng);
      end
   endtask

   task automatic wr(bit [7:0] a, bit [7:0] d);
      bus_wr = 1; bus_addr = a; bus_wdata = d;
      tick();
      bus_wr = 0;
   endtask

   task automatic rd(bit [7:0] a, string tag);
      bus_rd = 1; bus_addr = a;
      tick();
      bus_rd = 0;
      chk(bus_rdata == m_rd, tag, bus_rdata, m_rd);
   endtask

   initial begin
      #(8 * 150000);
      if (!done) begin
         n_fail++; n_chk++;
         $display("FAIL watchdog expired");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5EED_D5));
      @(negedge clk);
      repeat (3) tick();
      por_n = 1;
      tick();
      // R1: reset values, read back and at outputs
      for (int c = 0; c < NCH; c++) begin
         rd(8'(c*4), "R1 ctrl reset");
         chk(bus_rdata == 8'h00, "R1 ctrl literal", bus_rdata, 0);
         rd(8'(c*4+1), "R1 force reset");
         chk(bus_rdata == {1'b1, otp_f[c*VW +: VW]}, "R1 force literal", bus_rdata,
             {1'b1, otp_f[c*VW +: VW]});
         rd(8'(c*4+2), "R1 volt reset");
      end
      check_outs("R1 vsel", "R1 mode");

      // R2: command bit picks register
      wr(8'h01, 8'h11);
      chk(ch_vsel[6:0] == 7'h11, "R2 cmd0 force", ch_vsel[6:0], 7'h11);
      wr(8'h01, 8'h91);
      chk(ch_vsel[6:0] == otp_v[6:0], "R2 cmd1 volt", ch_vsel[6:0], otp_v[6:0]);

      // R3: pin selection with masks
      wr(8'h05, 8'h22);           // ch1 cmd=0, force code 0x22
      wr(8'h04, 8'h40);           // ch1 pin select on
      map_sleep = 3'b010;
      pin_sleep_n = 1; #1;
      chk(ch_vsel[13:7] == otp_v[13:7], "R3 deselected volt", ch_vsel[13:7], otp_v[13:7]);
      pin_sleep_n = 0; #1;
      chk(ch_vsel[13:7] == 7'h22, "R3 selected force", ch_vsel[13:7], 7'h22);
      pin_sleep_n = 1; pin_en1 = 1; #1;
      chk(ch_vsel[13:7] == otp_v[13:7], "R3 unmasked en1 ignored", ch_vsel[13:7], otp_v[13:7]);
      tick();
      check_outs("R3 vsel", "R4 mode");

      // R4: mode select and one-edge lag
      wr(8'h08, 8'h06);           // ch2 sleep=PWM, active=ECO
      chk(ch_mode[5:4] == 2'b00, "R4 lag", ch_mode[5:4], 0);
      tick();
      chk(ch_mode[5:4] == 2'b10, "R4 active mode", ch_mode[5:4], 2);
      map_en2 = 3'b100; pin_en2 = 1;
      tick();
      chk(ch_mode[5:4] == 2'b01, "R4 sleep mode", ch_mode[5:4], 1);
      rd(8'h08, "R4 status readback");

      // R7: range locked while on
      wr(8'h0A, 8'h05);
      chk(ch_range[2] == 1'b1, "R7 locked", ch_range[2], 1);
      wr(8'h08, 8'h00);
      tick();
      wr(8'h0A, 8'h05);
      chk(ch_range[2] == 1'b0, "R7 unlocked", ch_range[2], 0);

      // R5 / R6: warm reset
      wr(8'h04, 8'h80);           // ch1 keep through warm
      wr(8'h06, 8'h7F);
      warm_rst = 1; bus_wr = 1; bus_addr = 8'h02; bus_wdata = 8'h00;
      tick();
      warm_rst = 0; bus_wr = 0;
      rd(8'h01, "R5 force reload");
      chk(bus_rdata == {1'b1, otp_f[6:0]}, "R5 force literal", bus_rdata, {1'b1, otp_f[6:0]});
      rd(8'h02, "R6 write dropped");
      rd(8'h06, "R6 kept");
      chk(bus_rdata[6:0] == 7'h7F, "R6 kept literal", bus_rdata[6:0], 7'h7F);

      // R8: hardware reset
      wr(8'h00, 8'hCD);
      hw_rst_n = 0; tick(); hw_rst_n = 1;
      rd(8'h00, "R8 ctrl after hw reset");
      chk(bus_rdata == 8'h0D, "R8 literal", bus_rdata, 8'h0D);

      // R9 / R10: unmapped reads hold, status bits not writable
      wr(8'h00, 8'h30);
      rd(8'h00, "R9 status not writable");
      rd(8'h03, "R10 slot3 unmapped");
      rd(8'hFF, "R9 unmapped hold");
      wr(8'h0F, 8'hFF);
      wr(8'h13, 8'hFF);
      for (int c = 0; c < NCH; c++) rd(8'(c*4+1), "R10 unmapped write");
      check_outs("R10 vsel", "R4 mode");

      // R1: switch-off reset
      sw_rst_n = 0; tick(); sw_rst_n = 1;
      check_outs("R1 vsel", "R1 mode");

      // constrained random
      map_sleep = 3'($urandom); map_en1 = 3'($urandom); map_en2 = 3'($urandom);
      for (int i = 0; i < 4000; i++) begin
         int k;
         k = int'($urandom_range(0, 99));
         if (k < 10) begin pin_sleep_n = 1'($urandom); pin_en1 = 1'($urandom); pin_en2 = 1'($urandom); end
         warm_rst = ($urandom_range(0, 99) < 3);
         hw_rst_n = !($urandom_range(0, 199) == 0);
         sw_rst_n = !($urandom_range(0, 399) == 0);
         por_n    = !($urandom_range(0, 999) == 0);
         bus_wr = (k >= 10 && k < 60);
         bus_rd = (k >= 60);
         bus_addr = ($urandom_range(0, 9) == 0) ? 8'($urandom) : 8'($urandom_range(0, 11));
         bus_wdata = 8'($urandom);
         tick();
         if (bus_rd) chk(bus_rdata == m_rd, "R9 random read", bus_rdata, m_rd);
         check_outs("R2 R3 random vsel", "R4 random mode");
         warm_rst = 0; hw_rst_n = 1; sw_rst_n = 1; por_n = 1; bus_wr = 0; bus_rd = 0;
      end

      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule